// File: doc/BRIEF.md
# PCI Parity Error Reporter

This block checks even parity on a conventional PCI bus and reports failures with PCI timing. On every clock it folds the 32 address/data lines and the four command/byte-enable lines into one parity bit. On the next clock it compares that bit with the PAR line, which carries the parity for the previous clock. A mismatch found for an address phase becomes a one-clock low pulse on the system-error output. A mismatch found for a qualifying data phase becomes a low drive on the parity-error output. Both appear two clocks after the clock that carried the faulty lines.

The block takes the bus lines already sampled from the pads. It also takes FRAME#, IRDY# and TRDY#, a claimed flag that is true while this device asserts DEVSEL#, and a flag that is true when this device receives the data. It finds the address phase from FRAME# and latches the command from the command lines there. Each output is split into an output-enable and a value, so a pad cell can build the tri-state or open-drain driver. Two sticky status bits record detected parity errors and signalled system errors until reset. Both are set even when reporting is disabled.

Top module: `pci_parity_reporter`

## Requirements
- R1: While reset is asserted and after it is released with no activity, both output enables are 0, both values are 1 and both sticky status bits are 0.
- R2: Parity is even over 37 lines. A clock's lines are in error when the PAR value on the following clock differs from the XOR of `ad[31:0]` and `cbeN[3:0]`.
- R3: The address phase is the first clock with `frameN` low after a clock with `frameN` high. A parity error for an address phase drives `serrOe`=1 and `serrVal`=0 for exactly one clock, two clocks after the address phase, when `serrEn` is 1.
- R4: A data phase is checked only if, on that clock, `irdyN` and `trdyN` are both 0, `claimed` is 1 and `isRcvr` is 1. A parity error for such a phase drives `perrOe`=1 and `perrVal`=0 two clocks after that phase, when `perrEn` is 1.
- R5: A data clock that misses any condition of R4 is never reported and sets no status, whatever PAR holds.
- R6: When the command latched at the address phase is 4'h1 (special cycle), data-phase errors in that transaction are neither reported nor recorded. Address-phase checking still applies.
- R7: Consecutive data phases in error keep `perrVal` low for one clock per phase in error.
- R8: On the clock after the last low clock of the parity-error output, the output is driven high (`perrOe`=1, `perrVal`=1) for one clock. After that it is released (`perrOe`=0), unless a new error falls on that clock.
- R9: With `perrEn`=0 or `serrEn`=0 the matching output is never enabled. Status bits are still set.
- R10: `stsParityDet` is set by any reported-class error (address, or qualifying data). `stsSysErr` is set by address errors. Both update on the same clock as the outputs and hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ad | input | 32 | Sampled address/data lines |
| cbeN | input | 4 | Sampled command/byte-enable lines |
| par | input | 1 | Sampled parity line, covering the previous clock |
| frameN | input | 1 | Sampled FRAME#, active low |
| irdyN | input | 1 | Sampled IRDY#, active low |
| trdyN | input | 1 | Sampled TRDY#, active low |
| claimed | input | 1 | This device asserts DEVSEL# for the current access |
| isRcvr | input | 1 | This device is the data receiver in the current access |
| perrEn | input | 1 | Enables driving the parity-error output |
| serrEn | input | 1 | Enables driving the system-error output |
| perrOe | output | 1 | Parity-error output enable |
| perrVal | output | 1 | Parity-error value (0 = asserted) |
| serrOe | output | 1 | System-error output enable |
| serrVal | output | 1 | System-error value (0 = asserted) |
| stsParityDet | output | 1 | Sticky parity-error-detected status |
| stsSysErr | output | 1 | Sticky system-error-signalled status |

## Verification
Every result of this block is due exactly two clocks after the clock that carried the checked lines, one clock after the PAR value that covers them. The only later result is the one-clock high drive of R8, which comes on the third clock. The bench drives each clock's inputs on the falling edge and tags every event with the index of the clock on which it must show. It then compares outputs at the falling edge of that clock against a model kept per clock index. Its sweeps cover every mix of the handshake and claim flags, the special command, the enables and address or data corruption.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Strobes from control to datapath: which check applies to the
  // lines captured on the previous clock.
  typedef struct packed {
    logic chkAddr;
    logic chkData;
  } parStrobe_t;

endpackage

// File: rtl/pci_par_ctrl.sv
module pci_par_ctrl
  import pci_par_pkg::*;
#(
  parameter int CBE_W = 4,
  parameter logic [CBE_W-1:0] SPECIAL_CMD = 4'h1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CBE_W-1:0] cbeN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             claimed,
  input  logic             isRcvr,
  output parStrobe_t       stb
);

  logic             prevFrameN;
  logic [CBE_W-1:0] cmdQ;
  logic             addrPhase;
  logic             isSpecial;
  logic             dataDone;
  logic             dataQual;

  // First clock of FRAME# low marks the address phase.
  assign addrPhase = prevFrameN & ~frameN;
  assign isSpecial = (cmdQ == SPECIAL_CMD);
  assign dataDone  = ~irdyN & ~trdyN;
  assign dataQual  = dataDone & claimed & isRcvr & ~isSpecial;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFrameN  <= 1'b1;
      cmdQ        <= '0;
      stb.chkAddr <= 1'b0;
      stb.chkData <= 1'b0;
    end else begin
      prevFrameN  <= frameN;
      if (addrPhase) cmdQ <= cbeN;
      stb.chkAddr <= addrPhase;
      stb.chkData <= dataQual;
    end
  end

endmodule

// File: rtl/pci_par_dp.sv
module pci_par_dp
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbeN,
  input  logic             par,
  input  parStrobe_t       stb,
  input  logic             perrEn,
  input  logic             serrEn,
  output logic             perrOe,
  output logic             perrVal,
  output logic             serrOe,
  output logic             serrVal,
  output logic             stsParityDet,
  output logic             stsSysErr
);

  localparam int LINES_W = AD_W + CBE_W;

  logic [LINES_W-1:0] lines;
  logic [LINES_W-1:0] foldChain;
  logic               lineXorQ;
  logic               mismatch;
  logic               addrErr;
  logic               dataErr;
  logic               perrLowNext;
  logic               perrAct;
  logic               perrTail;
  logic               serrAct;

  assign lines = {ad, cbeN};

  // Ripple fold of the parity over all covered lines.
  assign foldChain[0] = lines[0];
  generate
    for (genvar i = 1; i < LINES_W; i++) begin : g_fold
      assign foldChain[i] = foldChain[i-1] ^ lines[i];
    end
  endgenerate

  assign mismatch    = lineXorQ ^ par;
  assign addrErr     = stb.chkAddr & mismatch;
  assign dataErr     = stb.chkData & mismatch;
  assign perrLowNext = dataErr & perrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineXorQ     <= 1'b0;
      perrAct      <= 1'b0;
      perrTail     <= 1'b0;
      serrAct      <= 1'b0;
      stsParityDet <= 1'b0;
      stsSysErr    <= 1'b0;
    end else begin
      lineXorQ     <= foldChain[LINES_W-1];
      perrAct      <= perrLowNext;
      perrTail     <= perrAct & ~perrLowNext;
      serrAct      <= addrErr & serrEn;
      stsParityDet <= stsParityDet | addrErr | dataErr;
      stsSysErr    <= stsSysErr | addrErr;
    end
  end

  assign perrOe  = perrAct | perrTail;
  assign perrVal = ~perrAct;
  assign serrOe  = serrAct;
  assign serrVal = ~serrAct;

endmodule

// File: rtl/pci_parity_reporter.sv
module pci_parity_reporter
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter logic [CBE_W-1:0] SPECIAL_CMD = 4'h1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbeN,
  input  logic             par,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             claimed,
  input  logic             isRcvr,
  input  logic             perrEn,
  input  logic             serrEn,
  output logic             perrOe,
  output logic             perrVal,
  output logic             serrOe,
  output logic             serrVal,
  output logic             stsParityDet,
  output logic             stsSysErr
);

  parStrobe_t stb;

  pci_par_ctrl #(
    .CBE_W      (CBE_W),
    .SPECIAL_CMD(SPECIAL_CMD)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cbeN   (cbeN),
    .frameN (frameN),
    .irdyN  (irdyN),
    .trdyN  (trdyN),
    .claimed(claimed),
    .isRcvr (isRcvr),
    .stb    (stb)
  );

  pci_par_dp #(
    .AD_W (AD_W),
    .CBE_W(CBE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ad          (ad),
    .cbeN        (cbeN),
    .par         (par),
    .stb         (stb),
    .perrEn      (perrEn),
    .serrEn      (serrEn),
    .perrOe      (perrOe),
    .perrVal     (perrVal),
    .serrOe      (serrOe),
    .serrVal     (serrVal),
    .stsParityDet(stsParityDet),
    .stsSysErr   (stsSysErr)
  );

endmodule

// File: rtl/pci_parity_reporter_chk.sv
module pci_parity_reporter_chk (
  input logic clk,
  input logic rstN,
  input logic perrEn,
  input logic serrEn,
  input logic perrOe,
  input logic perrVal,
  input logic serrOe,
  input logic serrVal,
  input logic stsParityDet,
  input logic stsSysErr
);

  // R3
  serr_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serrOe && !serrVal) |=> !serrOe);

  // R3
  serr_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    serrOe |-> (stsSysErr && stsParityDet));

  // R8
  perr_driven_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && !perrVal) |=> perrOe);

  // R8
  perr_high_follows_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && perrVal) |-> $past(perrOe && !perrVal));

  // R9
  perr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && !perrVal) |-> $past(perrEn));

  // R9
  serr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    serrOe |-> $past(serrEn));

  // R10
  det_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsParityDet |=> stsParityDet);

  // R10
  sys_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsSysErr |=> stsSysErr);

endmodule

bind pci_parity_reporter pci_parity_reporter_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .perrEn      (perrEn),
  .serrEn      (serrEn),
  .perrOe      (perrOe),
  .perrVal     (perrVal),
  .serrOe      (serrOe),
  .serrVal     (serrVal),
  .stsParityDet(stsParityDet),
  .stsSysErr   (stsSysErr)
);

// File: tb/tb_pci_parity_reporter.sv
`timescale 1ns/1ps
module tb_pci_parity_reporter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbeN = '0;
  logic        par = 1'b0;
  logic        frameN = 1'b1;
  logic        irdyN = 1'b1;
  logic        trdyN = 1'b1;
  logic        claimed = 1'b0;
  logic        isRcvr = 1'b0;
  logic        perrEn = 1'b0;
  logic        serrEn = 1'b0;
  logic        perrOe, perrVal, serrOe, serrVal, stsParityDet, stsSysErr;

  pci_parity_reporter dut (
    .clk(clk), .rstN(rstN), .ad(ad), .cbeN(cbeN), .par(par),
    .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .claimed(claimed), .isRcvr(isRcvr), .perrEn(perrEn), .serrEn(serrEn),
    .perrOe(perrOe), .perrVal(perrVal), .serrOe(serrOe), .serrVal(serrVal),
    .stsParityDet(stsParityDet), .stsSysErr(stsSysErr)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // Per-clock expectation model, indexed by clock since reset release.
  int          cyc;
  bit          perrEv [0:31];
  bit          serrEv [0:31];
  bit          detEv  [0:31];
  bit          sysEv  [0:31];
  bit          expDet, expSys;
  logic [31:0] prevAd;
  logic [3:0]  prevCbe;
  logic [3:0]  cmdModel;
  bit          prevFrame, prevAddr, prevData;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s clk=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; ad = '0; cbeN = '0; par = 1'b0; frameN = 1'b1;
    irdyN = 1'b1; trdyN = 1'b1; claimed = 1'b0; isRcvr = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs idle and status clear during reset
    chk("R1 perrOe", perrOe, 1'b0);
    chk("R1 perrVal", perrVal, 1'b1);
    chk("R1 serrOe", serrOe, 1'b0);
    chk("R1 serrVal", serrVal, 1'b1);
    chk("R1 stsParityDet", stsParityDet, 1'b0);
    chk("R1 stsSysErr", stsSysErr, 1'b0);
    rstN = 1'b1;
    for (int k = 0; k < 32; k++) begin
      perrEv[k] = 0; serrEv[k] = 0; detEv[k] = 0; sysEv[k] = 0;
    end
    cyc = 0; expDet = 0; expSys = 0; prevAd = '0; prevCbe = '0;
    cmdModel = '0; prevFrame = 1; prevAddr = 0; prevData = 0;
  endtask

  // One bus clock: drive at the falling edge, check this clock's outputs,
  // then update the model with the attributes of the lines just driven.
  task automatic step(input logic [31:0] a, input logic [3:0] cb,
                      input logic fN, input logic iN, input logic tN,
                      input logic cl, input logic rv, input logic bad);
    bit addrNow, dataNow, actNow, actPrev;
    @(negedge clk);
    ad = a; cbeN = cb; frameN = fN; irdyN = iN; trdyN = tN;
    claimed = cl; isRcvr = rv;
    // R2: even parity over the previous clock's lines, optionally corrupted
    par = (^{prevAd, prevCbe}) ^ bad;
    if (bad && prevAddr) begin
      detEv[cyc+1] = 1; sysEv[cyc+1] = 1;
      if (serrEn) serrEv[cyc+1] = 1;
    end
    if (bad && prevData) begin
      detEv[cyc+1] = 1;
      if (perrEn) perrEv[cyc+1] = 1;
    end
    if (detEv[cyc]) expDet = 1;
    if (sysEv[cyc]) expSys = 1;
    actNow  = perrEv[cyc];
    actPrev = (cyc > 0) ? perrEv[cyc-1] : 1'b0;
    // R4 R5 R6 R7 R9: low drive exactly on modelled error clocks
    chk("R4 R5 R6 R7 R9 perrVal", perrVal, !actNow);
    // R8: driven while low and for one clock after
    chk("R8 R9 perrOe", perrOe, actNow || actPrev);
    // R3 R9: one-clock system-error pulse
    chk("R3 R9 serrOe", serrOe, serrEv[cyc]);
    chk("R3 serrVal", serrVal, !serrEv[cyc]);
    // R10: sticky status
    chk("R10 R2 stsParityDet", stsParityDet, expDet);
    chk("R10 stsSysErr", stsSysErr, expSys);
    addrNow = !fN && prevFrame;
    dataNow = !iN && !tN && cl && rv && (cmdModel != 4'h1);
    if (addrNow) cmdModel = cb;
    prevAddr = addrNow; prevData = dataNow; prevFrame = fN;
    prevAd = a; prevCbe = cb;
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Sweep: claim, receiver, IRDY#, TRDY#, special command, enables,
    // address corruption, data corruption.
    for (int i = 0; i < 256; i++) begin
      logic [31:0] addr, dat;
      logic cl, rv, iN, tN, spec, en, badA, badD;
      {badD, badA, en, spec, tN, iN, rv, cl} = i[7:0];
      perrEn = en;
      serrEn = en ^ cl;
      addr = i * 32'h9E37_79B1;
      dat  = ~addr ^ 32'h0F0F_3C3C;
      doReset();
      step(32'h0, 4'h0, 1, 1, 1, 0, 0, 0);
      step(addr, spec ? 4'h1 : 4'h7, 0, 1, 1, 0, 0, 0);
      step(dat, 4'h0, 1, iN, tN, cl, rv, badA);
      step(32'h0, 4'hF, 1, 1, 1, 0, 0, badD);
      step(32'h0, 4'hF, 1, 1, 1, 0, 0, 0);
      step(32'h0, 4'hF, 1, 1, 1, 0, 0, 0);
      step(32'h0, 4'hF, 1, 1, 1, 0, 0, 0);
    end

    // R7 R8: burst of phases: err, err, ok, err, then idle
    perrEn = 1; serrEn = 1;
    doReset();
    step(32'h0, 4'h0, 1, 1, 1, 0, 0, 0);
    step(32'h1234_5678, 4'h7, 0, 1, 1, 0, 0, 0);
    step(32'hAAAA_0001, 4'h0, 0, 0, 0, 1, 1, 0);
    step(32'h5555_0002, 4'h0, 0, 0, 0, 1, 1, 1);
    step(32'hF0F0_0003, 4'h3, 0, 0, 0, 1, 1, 1);
    step(32'h0F0F_0004, 4'h0, 1, 0, 0, 1, 1, 0);
    step(32'h0, 4'hF, 1, 1, 1, 0, 0, 1);
    for (int k = 0; k < 5; k++) step(32'h0, 4'hF, 1, 1, 1, 0, 0, 0);

    // R7: three back-to-back errored phases, with R3 address error too
    doReset();
    step(32'h0, 4'h0, 1, 1, 1, 0, 0, 0);
    step(32'hDEAD_BEEF, 4'h6, 0, 1, 1, 0, 0, 0);
    step(32'h0000_00FF, 4'h0, 0, 0, 0, 1, 1, 1);
    step(32'h0000_FF00, 4'h0, 0, 0, 0, 1, 1, 1);
    step(32'h00FF_0000, 4'h0, 1, 0, 0, 1, 1, 1);
    step(32'h0, 4'hF, 1, 1, 1, 0, 0, 1);
    for (int k = 0; k < 5; k++) step(32'h0, 4'hF, 1, 1, 1, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule